// File: doc/BRIEF.md
# Range-Adaptive Successive-Approximation Conversion Controller

This block sequences a successive-approximation converter whose resolution depends on the size of the signal. A start pulse launches a conversion. The first step is a single range decision. During that step the block drives the DAC with a level equal to one eighth of full scale and reads the comparator once. It then runs a 9-step binary search, from the most significant bit down. Each step presents one trial word to the DAC and samples one comparator result.

The range decision sets two things: the span the external reference logic must use for the DAC, and the position of the 9-bit result inside a 12-bit output word. Small signals are converted with a span of one eighth of full scale. Their result sits in the low nine bits, with the three top bits at zero, which gives full 12-bit precision. Large signals are converted with the full span. Their result sits in the top nine bits, and the three bottom bits are filled from a free-running pseudo-random generator. Across the whole input range, the two placements together form one monotonic 12-bit ramp.

Top module: `sar_range_ctrl`

## Requirements
- R1: During the search, the DAC word is the bits already accepted, ORed with the bit under trial. The trial starts at bit 8 and moves down to bit 0, one bit per cycle. The trial bit is kept when `cmp_i` is 1, where 1 means the input is at or above the DAC level.
- R2: In the cycle after `start_i` is accepted, `dac_code_o` equals 64 and `range_hi_o` is 1. With the full-scale span, that code is one eighth of full scale. A comparator result of 1 in this cycle selects the high range.
- R3: In the low range, `result_o[11:9]` is 000 and `result_o[8:0]` is the 9-bit search result.
- R4: In the high range, `result_o[11:3]` is the 9-bit search result and `result_o[2:0]` holds pseudo-random bits.
- R5: `range_hi_o` carries the range decision and stays unchanged through all nine search cycles and the idle time that follows. A value of 0 means the DAC span is one eighth of full scale. A value of 1 means the span is full scale.
- R6: If `start_i` is sampled at clock edge N, `done_o` is high for exactly one cycle, after edge N+11. `result_o` updates at that same edge and then holds until the next conversion completes.
- R7: The random bits are the low bits of a free-running 16-bit maximal-length LFSR with a nonzero seed. The LFSR is sampled at the edge that completes the conversion, and its state never becomes zero.
- R8: A `start_i` pulse that arrives while a conversion is in progress, including the output cycle, has no effect. The running conversion keeps its timing and result, and no second conversion follows.
- R9: While `rst_n` is low at a clock edge, the block returns to idle, `result_o` is cleared to 0, and `done_o`, `range_hi_o` and `dac_code_o` are driven to 0.
- R10: Over a rising input ramp, the output code with its random bits masked off never decreases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Conversion request, sampled while idle |
| cmp_i | input | 1 | Comparator result: 1 when the input is at or above the DAC level |
| dac_code_o | output | 9 | DAC trial word |
| range_hi_o | output | 1 | DAC span select: 1 for full scale, 0 for one eighth of full scale |
| result_o | output | 12 | Formatted conversion result |
| done_o | output | 1 | One-cycle pulse when `result_o` is updated |

## Verification
The bench sweeps all 4096 input levels of an ideal comparator-and-DAC model. This walks both ranges and exposes errors in bit order, bit placement and range selection. It also exposes off-by-one errors at the threshold, because levels 511 and 512 land on opposite sides. At every level the trial words are compared step by step against words computed from the input, so a wrong keep/drop rule shows up at the bit where it first goes wrong. Start pulses are injected at each busy cycle in turn to show they are ignored. A reset in the middle of a conversion checks that the result is cleared. The low random bits are collected across the high range to confirm that all eight values appear.

// File: rtl/sar_range_pkg.sv
// Package sar_range_pkg
// Shared types for the range-adaptive SAR controller.
// Assumes: a single clock domain; all users import this package.
package sar_range_pkg;

    // Conversion sequence phases
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RANGE  = 2'd1,
        ST_SEARCH = 2'd2,
        ST_EMIT   = 2'd3
    } conv_state_e;

endpackage

// File: rtl/sar_lfsr.sv
// Module sar_lfsr
// Free-running Galois LFSR. It shifts right on every clock and, after
// reset, never stops.
// Assumes: TAPS describes a maximal-length polynomial and SEED is nonzero,
// so the register never reaches the all-zero lock-up state.
module sar_lfsr #(
    parameter int              WIDTH = 16,
    parameter logic [WIDTH-1:0] TAPS = 16'hB400,
    parameter logic [WIDTH-1:0] SEED = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [WIDTH-1:0] state_o
);

    logic [WIDTH-1:0] lfsr_q;

    // Advance the register one step per clock; reload the seed on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lfsr_q <= SEED;
        end else begin
            lfsr_q <= {1'b0, lfsr_q[WIDTH-1:1]} ^ (lfsr_q[0] ? TAPS : '0);
        end
    end

    assign state_o = lfsr_q;

endmodule

// File: rtl/sar_seq.sv
// Module sar_seq
// Sequencer for one conversion: a range decision, a binary search of
// SAR_BITS steps from the MSB down, then a single emit cycle.
// Assumes: cmp_i reflects the DAC word driven in the same cycle (the
// external DAC and comparator settle within one clock), and a 1 on cmp_i
// means the input is at or above the DAC level.
module sar_seq
    import sar_range_pkg::*;
#(
    parameter int SAR_BITS    = 9,
    parameter int THRESH_CODE = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                cmp_i,
    output conv_state_e         state_o,
    output logic                range_hi_o,
    output logic [SAR_BITS-1:0] dac_code_o,
    output logic [SAR_BITS-1:0] sar_word_o,
    output logic                emit_o
);

    localparam logic [SAR_BITS-1:0] TOP_BIT   = {1'b1, {(SAR_BITS-1){1'b0}}};
    localparam logic [SAR_BITS-1:0] THRESH_W  = SAR_BITS'(THRESH_CODE);

    conv_state_e         state_q;
    logic                range_q;
    logic [SAR_BITS-1:0] acc_q;
    logic [SAR_BITS-1:0] trial_q;

    // Phase transitions, range capture and bit-by-bit approximation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            range_q <= 1'b0;
            acc_q   <= '0;
            trial_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_RANGE;
                    end
                end
                ST_RANGE: begin
                    range_q <= cmp_i;
                    acc_q   <= '0;
                    trial_q <= TOP_BIT;
                    state_q <= ST_SEARCH;
                end
                ST_SEARCH: begin
                    if (cmp_i) begin
                        acc_q <= acc_q | trial_q;
                    end
                    trial_q <= trial_q >> 1;
                    if (trial_q[0]) begin
                        state_q <= ST_EMIT;
                    end
                end
                ST_EMIT: begin
                    state_q <= ST_IDLE;
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // DAC word for the current phase: threshold, trial word, or idle zero
    always_comb begin
        case (state_q)
            ST_RANGE:  dac_code_o = THRESH_W;
            ST_SEARCH: dac_code_o = acc_q | trial_q;
            default:   dac_code_o = '0;
        endcase
    end

    // Span select: full scale while deciding the range, then the held decision
    always_comb begin
        range_hi_o = (state_q == ST_RANGE) ? 1'b1 : range_q;
    end

    assign state_o    = state_q;
    assign sar_word_o = acc_q;
    assign emit_o     = (state_q == ST_EMIT);

endmodule

// File: rtl/sar_fmt.sv
// Module sar_fmt
// Places the search result inside the wide output word.
// Fine range: the result is right-aligned and the top bits are zero.
// Coarse range: the result is left-aligned and the bottom bits come from
// the random source.
// Assumes: OUT_BITS > SAR_BITS and RND_W >= OUT_BITS - SAR_BITS.
module sar_fmt #(
    parameter int SAR_BITS = 9,
    parameter int OUT_BITS = 12,
    parameter int RND_W    = 16
) (
    input  logic                range_hi_i,
    input  logic [SAR_BITS-1:0] sar_word_i,
    input  logic [RND_W-1:0]    rnd_i,
    output logic [OUT_BITS-1:0] word_o
);

    localparam int PAD = OUT_BITS - SAR_BITS;

    logic [OUT_BITS-1:0] fine_w;
    logic [OUT_BITS-1:0] coarse_w;

    generate
        if (PAD > 0) begin : g_pad
            assign fine_w   = {{PAD{1'b0}}, sar_word_i};
            assign coarse_w = {sar_word_i, rnd_i[PAD-1:0]};
        end else begin : g_nopad
            assign fine_w   = sar_word_i[OUT_BITS-1:0];
            assign coarse_w = sar_word_i[OUT_BITS-1:0];
        end
    endgenerate

    // Select placement from the range decision
    always_comb begin
        word_o = range_hi_i ? coarse_w : fine_w;
    end

endmodule

// File: rtl/sar_range_ctrl.sv
// Module sar_range_ctrl (top)
// Range-adaptive SAR conversion controller. It sequences the range
// decision and the binary search, formats the result into OUT_BITS, and
// registers the result with a one-cycle done pulse.
// Assumes: the external DAC scales its reference by 2**PAD when
// range_hi_o is 0, and the comparator settles within one clock.
module sar_range_ctrl
    import sar_range_pkg::*;
#(
    parameter int SAR_BITS = 9,
    parameter int OUT_BITS = 12,
    parameter int LFSR_W   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                cmp_i,
    output logic [SAR_BITS-1:0] dac_code_o,
    output logic                range_hi_o,
    output logic [OUT_BITS-1:0] result_o,
    output logic                done_o
);

    localparam int PAD         = OUT_BITS - SAR_BITS;
    localparam int THRESH_CODE = 1 << (SAR_BITS - PAD);

    conv_state_e         seq_state;
    logic [SAR_BITS-1:0] sar_word;
    logic                emit;
    logic [LFSR_W-1:0]   lfsr_q;
    logic [OUT_BITS-1:0] fmt_word;
    logic [OUT_BITS-1:0] result_q;
    logic                done_q;

    sar_seq #(
        .SAR_BITS    (SAR_BITS),
        .THRESH_CODE (THRESH_CODE)
    ) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .cmp_i      (cmp_i),
        .state_o    (seq_state),
        .range_hi_o (range_hi_o),
        .dac_code_o (dac_code_o),
        .sar_word_o (sar_word),
        .emit_o     (emit)
    );

    sar_lfsr #(
        .WIDTH (LFSR_W)
    ) lfsr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_o (lfsr_q)
    );

    sar_fmt #(
        .SAR_BITS (SAR_BITS),
        .OUT_BITS (OUT_BITS),
        .RND_W    (LFSR_W)
    ) fmt_i (
        .range_hi_i (range_hi_o),
        .sar_word_i (sar_word),
        .rnd_i      (lfsr_q),
        .word_o     (fmt_word)
    );

    // Capture the formatted word and raise done for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= emit;
            if (emit) begin
                result_q <= fmt_word;
            end
        end
    end

    assign result_o = result_q;
    assign done_o   = done_q;

endmodule

// File: rtl/sar_range_ctrl_chk.sv
// Module sar_range_ctrl_chk
// Property checker for sar_range_ctrl, attached with bind below.
// Assumes: it sees the sequencer phase and the LFSR state of the top.
module sar_range_ctrl_chk
    import sar_range_pkg::*;
#(
    parameter int SAR_BITS = 9,
    parameter int OUT_BITS = 12,
    parameter int LFSR_W   = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start_i,
    input logic [SAR_BITS-1:0] dac_code_o,
    input logic                range_hi_o,
    input logic [OUT_BITS-1:0] result_o,
    input logic                done_o,
    input conv_state_e         state_i,
    input logic [LFSR_W-1:0]   lfsr_i
);

    localparam int PAD = OUT_BITS - SAR_BITS;
    localparam logic [SAR_BITS-1:0] THRESH = SAR_BITS'(1 << (SAR_BITS - PAD));

    // R2: range phase presents the threshold on the full span
    assert_range_probe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state_i == ST_RANGE |-> (dac_code_o == THRESH && range_hi_o));

    // R3: fine range result has zero top bits
    assert_fine_top_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !range_hi_o) |-> result_o[OUT_BITS-1:SAR_BITS] == '0);

    // R5: span select frozen across the search
    assert_span_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_SEARCH && $past(state_i) == ST_SEARCH) |-> $stable(range_hi_o));

    // R6: done is a single-cycle pulse following the emit phase
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_done_after_emit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(state_i) == ST_EMIT);

    // R7: random source never locks up
    assert_lfsr_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_i != '0);

    // R8: a start seen while busy never restarts the range phase
    assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && state_i != ST_IDLE) |=> state_i != ST_RANGE);

    // R9: reset clears the result and done
    assert_reset_clear_R9: assert property (@(posedge clk)
        !rst_n |=> (result_o == '0 && !done_o));

endmodule

bind sar_range_ctrl sar_range_ctrl_chk #(
    .SAR_BITS (SAR_BITS),
    .OUT_BITS (OUT_BITS),
    .LFSR_W   (LFSR_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .dac_code_o (dac_code_o),
    .range_hi_o (range_hi_o),
    .result_o   (result_o),
    .done_o     (done_o),
    .state_i    (seq_state),
    .lfsr_i     (lfsr_q)
);

// File: tb/sar_range_ctrl_tb_top.sv
// Bench for sar_range_ctrl: an ideal DAC/comparator model and a full
// input sweep, with expected codes computed arithmetically.
`timescale 1ns/1ps
module sar_range_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic        cmp;
    logic [8:0]  dac;
    logic        range_hi;
    logic [11:0] result;
    logic        done;

    int vin;
    int total = 0;
    int bad   = 0;
    logic [7:0] rnd_seen = '0;

    always #2.5 clk = ~clk;

    // Ideal analog model in 1/4096 full-scale units
    always_comb begin
        cmp = (range_hi ? int'(dac) * 8 : int'(dac)) <= vin;
    end

    sar_range_ctrl dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .cmp_i      (cmp),
        .dac_code_o (dac),
        .range_hi_o (range_hi),
        .result_o   (result),
        .done_o     (done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (vin=%0d)", req, act, exp, vin);
        end
    endtask

    // One conversion; kick>0 drives a stray start at that busy cycle
    task automatic convert(input int v, input int kick, output logic [11:0] res);
        bit hi;
        int code;
        int bad_trial;
        int bad_span;
        int exp_trial;
        int act_trial;
        vin  = v;
        hi   = (v >= 512);
        code = hi ? (v >> 3) : v;
        bad_trial = 0;
        bad_span  = 0;
        exp_trial = 0;
        act_trial = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(dac == 9'd64 && range_hi == 1'b1, "R2", int'(dac), 64);
        for (int k = 1; k <= 11; k++) begin
            @(negedge clk);
            start = (k == kick);
            if (k <= 9) begin
                int idx;
                int e;
                idx = 9 - k;
                e = ((code >> (idx + 1)) << (idx + 1)) | (1 << idx);
                if (int'(dac) != e && bad_trial == 0) begin
                    bad_trial = 1;
                    exp_trial = e;
                    act_trial = int'(dac);
                end
                if (range_hi != hi) bad_span = 1;
            end
            if (k < 11) chk(done == 1'b0, "R6", int'(done), 0);
            else        chk(done == 1'b1, "R6", int'(done), 1);
        end
        start = 1'b0;
        chk(bad_trial == 0, "R1", act_trial, exp_trial);
        chk(bad_span == 0, "R5", int'(range_hi), int'(hi));
        res = result;
        if (hi) begin
            chk(int'(result >> 3) == code, "R4", int'(result >> 3), code);
            rnd_seen[result[2:0]] = 1'b1;
        end else begin
            chk(int'(result) == code, "R3", int'(result), code);
        end
        @(negedge clk);
        chk(done == 1'b0 && result == res, "R6", int'(result), int'(res));
        if (kick > 0) begin
            chk(dac == 9'd0 && done == 1'b0, "R8", int'(dac), 0);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [11:0] r;
        int prev_key;
        int key;
        rst_n = 1'b0;
        start = 1'b0;
        vin   = 0;
        repeat (3) @(negedge clk);
        chk(result == 12'd0 && done == 1'b0, "R9", int'(result), 0);
        chk(range_hi == 1'b0 && dac == 9'd0, "R9", int'(dac), 0);
        rst_n = 1'b1;
        @(negedge clk);

        prev_key = -1;
        for (int v = 0; v < 4096; v++) begin
            int kick;
            kick = ((v % 13) == 5) ? ((v % 10) + 1) : 0;
            convert(v, kick, r);
            key = (v >= 512) ? int'(r & 12'hFF8) : int'(r);
            chk(key >= prev_key, "R10", key, prev_key);
            prev_key = key;
        end
        chk(rnd_seen == 8'hFF, "R7", int'(rnd_seen), 255);

        // Reset in the middle of a conversion clears the result
        vin = 3000;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(result == 12'd0 && done == 1'b0, "R9", int'(result), 0);
        chk(range_hi == 1'b0 && dac == 9'd0, "R9", int'(range_hi), 0);
        rst_n = 1'b1;
        repeat (12) @(negedge clk);
        chk(done == 1'b0 && result == 12'd0, "R9", int'(result), 0);
        convert(100, 0, r);
        convert(511, 0, r);
        convert(512, 0, r);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule